// File: doc/BRIEF.md
# Interleaved SAR Section Sequencer

This block sequences a sixteen-way time-interleaved successive-approximation converter from a single clock. Each section works through a fixed sixteen-cycle frame. The frame has a reference-zero sample, an auto-zero compare, a calibration compare and an input sample, then eleven bit decisions (most significant bit first) and a transfer slot. Adjacent sections run one clock apart, so exactly one section samples the analog input on every rising edge and the whole pattern repeats every sixteen clocks.

Each section owns an eleven-bit SAR register that is driven by its own comparator input. In every bit step the trial bit is set, and it is dropped on the following edge if the comparator reports that the trial code lies above the input. When a section reaches its transfer slot it raises its done bit, and the shared result bus carries its code. The result therefore appears twelve clocks after that section's input sample.

A power-up counter raises a ready flag once enough clock edges have elapsed for the background calibration to settle. The analog parts are outside the block: track-and-hold, comparators, DAC and calibration voltages.

Top module: `sar_interleave_seq`

## Requirements
- R1: In frame phase p (0 to 15, zero in the first cycle after reset), `refz_stb` is one-hot on section p, `az_stb` on section (p-1) mod 16 and `calcmp_stb` on section (p-2) mod 16.
- R2: `sample_sel` is one-hot on section (p-3) mod 16 in every cycle, so every clock samples the input exactly once.
- R3: `conv_act` is high for exactly the eleven sections whose offset (p-k) mod 16 lies in 4..14.
- R4: A section decides result bit 10 at offset 4 down to bit 0 at offset 14. During the step for bit b, `cmp_in[k]`=1 means the trial code exceeds the input, which clears bit b. `cmp_in[k]`=0 keeps bit b.
- R5: `done` is one-hot on section (p+1) mod 16 (offset 15). In that cycle `result` equals the code decided from the input sample taken twelve cycles earlier.
- R6: A section that has not sampled since reset raises no `done`. While `done` is all zero, `result` is zero.
- R7: `cmp_in` of a section that is not in a bit step has no effect on any result.
- R8: `cal_ready` is low for the first CAL_CYCLES cycles after reset, rises after CAL_CYCLES rising edges and then stays high.
- R9: While `rst` is high (synchronous, active high), the phase is held at zero, `done`, `result` and `cal_ready` are zero, and releasing reset restarts the calibration count.
- R10: The frame phase advances on every rising edge and wraps from 15 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmp_in | input | 16 | Per-section comparator decision, 1 = trial above input |
| refz_stb | output | 16 | Reference-zero sampling strobe per section |
| az_stb | output | 16 | Auto-zero comparison strobe per section |
| calcmp_stb | output | 16 | Calibration comparison strobe per section |
| sample_sel | output | 16 | One-hot input-sampling select |
| conv_act | output | 16 | Section is in a bit-decision step |
| done | output | 16 | One-cycle transfer pulse per section |
| result | output | 11 | Code of the section currently transferring |
| cal_ready | output | 1 | Calibration period elapsed |

## Verification
A wrong phase count or a wrong per-section offset shows on the strobe and select vectors in the very next cycle. A fault in the bit-step logic shows as a wrong `result` twelve cycles after the affected sample. The test codes include all-zero and all-one values and alternating patterns, so an error in the decision order or in the trial bit handling changes at least one code. Sections outside their bit steps get pseudo-random comparator values, so any leak of those inputs into a result also appears at the transfer slot. Faults in the ready counter show within one cycle of the CAL_CYCLES boundary.

// File: rtl/sar_interleave_seq.sv
module sar_interleave_seq #(
  parameter int NBITS      = 11,
  parameter int CAL_CYCLES = 10000,
  localparam int FRAME     = NBITS + 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [FRAME-1:0] cmp_in,
  output logic [FRAME-1:0] refz_stb,
  output logic [FRAME-1:0] az_stb,
  output logic [FRAME-1:0] calcmp_stb,
  output logic [FRAME-1:0] sample_sel,
  output logic [FRAME-1:0] conv_act,
  output logic [FRAME-1:0] done,
  output logic [NBITS-1:0] result,
  output logic             cal_ready
);
  localparam int PH_W     = $clog2(FRAME);
  localparam int CNT_W    = $clog2(CAL_CYCLES + 1);
  localparam int ST_REFZ  = 0;
  localparam int ST_AZ    = 1;
  localparam int ST_CALC  = 2;
  localparam int ST_SAMP  = 3;
  localparam int ST_FIRST = 4;
  localparam int ST_LAST  = NBITS + 3;
  localparam int ST_XFER  = NBITS + 4;

  logic [PH_W-1:0]  ph;
  logic [CNT_W-1:0] cal_cnt;
  logic [FRAME-1:0][NBITS-1:0] part;

  always_ff @(posedge clk) begin
    if (rst) ph <= '0;
    else     ph <= (ph == PH_W'(FRAME-1)) ? '0 : ph + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                 cal_cnt <= '0;
    else if (!cal_ready)     cal_cnt <= cal_cnt + 1'b1;
  end
  assign cal_ready = (cal_cnt == CNT_W'(CAL_CYCLES));

  for (genvar k = 0; k < FRAME; k++) begin : g_sec
    logic [PH_W-1:0]  lstep;
    logic [PH_W-1:0]  cur_b;
    logic [NBITS-1:0] bmask;
    logic [NBITS-1:0] sar;
    logic             vld;

    assign lstep = (ph >= PH_W'(k)) ? ph - PH_W'(k) : PH_W'(32'(ph) + FRAME - k);
    assign refz_stb[k]   = (lstep == PH_W'(ST_REFZ));
    assign az_stb[k]     = (lstep == PH_W'(ST_AZ));
    assign calcmp_stb[k] = (lstep == PH_W'(ST_CALC));
    assign sample_sel[k] = (lstep == PH_W'(ST_SAMP));
    assign conv_act[k]   = (lstep >= PH_W'(ST_FIRST)) && (lstep <= PH_W'(ST_LAST));
    assign done[k]       = (lstep == PH_W'(ST_XFER)) && vld;
    assign cur_b         = PH_W'(ST_LAST) - lstep;
    assign bmask         = conv_act[k] ? (NBITS'(1) << cur_b) : '0;
    assign part[k]       = done[k] ? sar : '0;

    always_ff @(posedge clk) begin
      if (rst) begin
        sar <= '0;
        vld <= 1'b0;
      end else if (sample_sel[k]) begin
        sar <= {1'b1, {(NBITS-1){1'b0}}};
        vld <= 1'b1;
      end else if (conv_act[k]) begin
        sar <= (sar & ~(cmp_in[k] ? bmask : '0)) | (bmask >> 1);
      end
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
      $onehot0({refz_stb[k], az_stb[k], calcmp_stb[k], sample_sel[k], conv_act[k], done[k]})); // R1
    AST_SAMPLE_TO_DONE: assert property (@(posedge clk) disable iff (rst)
      sample_sel[k] |-> ##(NBITS+1) done[k]); // R5
    AST_AZ_FOLLOWS_REFZ: assert property (@(posedge clk) disable iff (rst)
      refz_stb[k] |=> az_stb[k]); // R1
  end

  always_comb begin
    result = '0;
    for (int k = 0; k < FRAME; k++) result = result | part[k];
  end

  AST_ONE_SAMPLER: assert property (@(posedge clk) disable iff (rst)
    $countones(sample_sel) == 1); // R2
  AST_CONV_COUNT: assert property (@(posedge clk) disable iff (rst)
    $countones(conv_act) == NBITS); // R3
  AST_DONE_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
    $onehot0(done)); // R5
  AST_IDLE_RESULT: assert property (@(posedge clk) disable iff (rst)
    (done == '0) |-> (result == '0)); // R6
  AST_CAL_HOLD: assert property (@(posedge clk) disable iff (rst)
    cal_ready |=> cal_ready); // R8
  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_W'(FRAME-1)) |=> (ph == '0)); // R10
endmodule

// File: tb/tb_sar_interleave_seq.sv
module tb_sar_interleave_seq;
  localparam int N  = 16;
  localparam int NB = 11;
  localparam int CAL = 10000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]  cmp_in = '0;
  logic [N-1:0]  refz_stb, az_stb, calcmp_stb, sample_sel, conv_act, done;
  logic [NB-1:0] result;
  logic          cal_ready;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int off = 0;
  logic [15:0] lfsr = 16'hACE1;

  localparam logic [10:0] VEC [24] = '{
    11'h000, 11'h7FF, 11'h400, 11'h3FF, 11'h001, 11'h555,
    11'h2AA, 11'h7FE, 11'h200, 11'h123, 11'h6DB, 11'h0F0,
    11'h70F, 11'h002, 11'h7FD, 11'h1A5, 11'h5A5, 11'h333,
    11'h4CC, 11'h080, 11'h7C0, 11'h03F, 11'h600, 11'h0AA};

  sar_interleave_seq #(.NBITS(NB), .CAL_CYCLES(CAL)) dut (
    .clk(clk), .rst(rst), .cmp_in(cmp_in), .refz_stb(refz_stb), .az_stb(az_stb),
    .calcmp_stb(calcmp_stb), .sample_sel(sample_sel), .conv_act(conv_act),
    .done(done), .result(result), .cal_ready(cal_ready));

  always #4 clk = ~clk;

  function automatic logic [10:0] tgt(int n);
    return VEC[(n + off) % 24];
  endfunction

  function automatic logic [N-1:0] oh(int s);
    return N'(1) << (s % N);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", req, what, cyc, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic run(int ncyc, bit cal_check);
    for (int i = 0; i < ncyc; i++) begin
      int p = cyc % N;
      logic [N-1:0] cv = lfsr;
      logic [N-1:0] ex_conv = '0;
      logic [N-1:0] ex_done = '0;
      logic [NB-1:0] ex_res = '0;
      for (int j = 1; j <= NB; j++) begin
        if (cyc - j >= 0) begin
          int n = cyc - j;
          logic [10:0] t = tgt(n);
          cv[(n + 13) % N] = ~t[NB - j];
        end
      end
      cmp_in = cv;
      for (int k = 0; k < N; k++) begin
        int d = (p - k + N) % N;
        if (d >= 4 && d <= 14) ex_conv[k] = 1'b1;
      end
      if (cyc >= 12) begin
        ex_done = oh(p + 1);
        ex_res = tgt(cyc - 12);
      end
      #1;
      chk(refz_stb == oh(p), "R1 R10", "refz_stb", 32'(refz_stb), 32'(oh(p)));
      chk(az_stb == oh(p + 15), "R1", "az_stb", 32'(az_stb), 32'(oh(p + 15)));
      chk(calcmp_stb == oh(p + 14), "R1", "calcmp_stb", 32'(calcmp_stb), 32'(oh(p + 14)));
      chk(sample_sel == oh(p + 13), "R2", "sample_sel", 32'(sample_sel), 32'(oh(p + 13)));
      chk(conv_act == ex_conv, "R3", "conv_act", 32'(conv_act), 32'(ex_conv));
      chk(done == ex_done, "R5 R6", "done", 32'(done), 32'(ex_done));
      chk(result == ex_res, "R4 R7", "result", 32'(result), 32'(ex_res));
      if (cal_check)
        chk(cal_ready == (cyc >= CAL), "R8", "cal_ready", 32'(cal_ready), 32'(cyc >= CAL));
      @(posedge clk);
      cyc++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cmp_in = '1;
    repeat (3) begin
      @(negedge clk);
      #1;
      chk(done == '0, "R9", "done in reset", 32'(done), 0);
      chk(result == '0, "R9", "result in reset", 32'(result), 0);
      chk(cal_ready == 1'b0, "R9", "cal_ready in reset", 32'(cal_ready), 0);
      chk(sample_sel == oh(13), "R9", "phase in reset", 32'(sample_sel), 32'(oh(13)));
    end
    @(negedge clk);
    rst = 1'b0;
    cyc = 0;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    do_reset();
    run(CAL + 8, 1'b1);
    off = 7;
    do_reset();
    run(60, 1'b1);
    off = 13;
    do_reset();
    run(40, 1'b0);
    summary();
  end
endmodule